// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block produces a pseudo-random byte stream from a 128-bit seed key. Eight identical cells run side by side. Each cell holds three shift registers of lengths 38, 43 and 47 bits, which together hold exactly 128 bits. The registers are clocked irregularly under a majority vote. Each cell gives one bit per step, and the eight bits form one keystream byte. The stream is meant to supply a fresh 128-bit round key for every 128-bit data block of a block cipher. Each group of sixteen bytes is packed into such a key and announced with a one-cycle ready pulse.

The same key goes to all eight cells, but cell n first rotates it left by 16·n bits so that every cell starts from a different state. After a load, the generator runs a number of warm-up steps whose output is discarded, and only then presents bytes.

A small controller with three states runs the sequence:
- `ST_IDLE`: the state after reset. Steps are ignored here.
- `ST_WARM`: entered from any state when a load strobe is seen. Accepted steps count toward the warm-up length and produce no byte.
- `ST_RUN`: entered from `ST_WARM` on the last warm-up step. Each accepted step yields one byte.

A load strobe always returns the controller to `ST_WARM`.

Top module: `kstream_gen`

## Requirements
- R1: After reset, `ks_valid`, `rkey_ready`, `rkey` and `ks_byte` are all zero. Steps given before the first load produce no valid byte.
- R2: On a load, cell n takes the key rotated left by 16·n bits and calls it r. Register A stage j takes r[j] for j = 0..37. Register B stage j takes r[38+j]. Register C stage j takes r[81+j]. Right after a load, `ks_byte` already shows the output function (R5) of this loaded state.
- R3: Each register shifts toward higher stage numbers, and stage 0 receives the feedback bit. The feedback is the XOR of these 0-based stages: A uses stages 37, 5, 4 and 0; B uses stages 42, 5, 3 and 2; C uses stages 46 and 4.
- R4: The clocking taps are A stage 19, B stage 21 and C stage 23. On an accepted step, a register shifts only if its clocking tap equals the majority of the three taps. The other registers keep their contents.
- R5: Bit n of `ks_byte` is the XOR of the top stages (A[37], B[42], C[46]) of cell n. `ks_valid` is high for exactly the one cycle after an accepted step in `ST_RUN`, and `ks_byte` then shows the state after that step.
- R6: After a load, the first 64 accepted steps produce no valid byte. The 65th accepted step produces the first one.
- R7: Sixteen valid bytes form one key: the k-th byte (k = 0..15) goes to bits 8k+7..8k. `rkey_ready` is high for one cycle, in the cycle after the sixteenth `ks_valid`. `rkey` holds its value until the next key is complete.
- R8: A load strobe in the same cycle as a step wins, and the step is not taken. A load restarts the warm-up and clears the byte count. A byte shown in the load cycle is not collected.
- R9: In a cycle with no step and no load, no register changes. `ks_byte` holds its value and `ks_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 128 | Seed key, sampled on a load |
| key_load | input | 1 | Load strobe |
| step | input | 1 | Advance the generator by one step |
| ks_byte | output | 8 | Keystream byte, one bit per cell |
| ks_valid | output | 1 | Byte valid, one cycle per step in `ST_RUN` |
| rkey | output | 128 | Last assembled 128-bit round key |
| rkey_ready | output | 1 | One-cycle pulse when `rkey` is updated |

## Verification
The bench builds the block with its default parameters: eight cells, a 128-bit key, 16-bit rotation per cell and 64 warm-up steps. This brings the full warm-up boundary (R6), the exact sixteen-byte key boundary (R7) and all three register lengths with their real taps into every run. Random keys and random idle gaps between steps exercise the majority clocking. Directed cases add an all-zero key, a load in the same cycle as a step, and a reload in the middle of a key.

// File: rtl/kstream_pkg.sv
package kstream_pkg;

    // register lengths of one cell
    localparam int LEN_A = 38;
    localparam int LEN_B = 43;
    localparam int LEN_C = 47;

    // feedback masks, bit j set = stage j is a feedback tap
    localparam logic [LEN_A-1:0] MASK_A = 38'h2000000031;    // stages 37,5,4,0
    localparam logic [LEN_B-1:0] MASK_B = 43'h4000000002C;   // stages 42,5,3,2
    localparam logic [LEN_C-1:0] MASK_C = 47'h400000000010;  // stages 46,4

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WARM = 2'd1,
        ST_RUN  = 2'd2
    } ks_state_t;

endpackage

// File: rtl/kstream_lfsr.sv
module kstream_lfsr #(
    parameter int             LEN     = 38,
    parameter logic [LEN-1:0] FB_MASK = '0,
    parameter int             CTL_IDX = LEN / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_val,
    input  logic           shift,
    output logic           ctl_bit,
    output logic           msb
);

    logic [LEN-1:0] st_q;
    logic           fb;

    assign fb      = ^(st_q & FB_MASK);
    assign ctl_bit = st_q[CTL_IDX];
    assign msb     = st_q[LEN-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= load_val;
        end else if (shift) begin
            st_q <= {st_q[LEN-2:0], fb};
        end
    end

    // R2: a load places the presented value in the register
    assert_load_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q == $past(load_val)));

    // R9: nothing moves without a load or shift
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(st_q));

endmodule

// File: rtl/kstream_cell.sv
module kstream_cell
    import kstream_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] cell_key,
    input  logic             step_en,
    output logic             out_bit
);

    logic tap_a, tap_b, tap_c;
    logic top_a, top_b, top_c;
    logic maj;
    logic en_a, en_b, en_c;

    assign maj  = (tap_a & tap_b) | (tap_a & tap_c) | (tap_b & tap_c);
    assign en_a = step_en & (tap_a ~^ maj);
    assign en_b = step_en & (tap_b ~^ maj);
    assign en_c = step_en & (tap_c ~^ maj);

    assign out_bit = top_a ^ top_b ^ top_c;

    kstream_lfsr #(.LEN(LEN_A), .FB_MASK(MASK_A)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(cell_key[LEN_A-1:0]),
        .shift(en_a), .ctl_bit(tap_a), .msb(top_a)
    );

    kstream_lfsr #(.LEN(LEN_B), .FB_MASK(MASK_B)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(cell_key[LEN_A+LEN_B-1:LEN_A]),
        .shift(en_b), .ctl_bit(tap_b), .msb(top_b)
    );

    kstream_lfsr #(.LEN(LEN_C), .FB_MASK(MASK_C)) u_reg_c (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(cell_key[KEY_W-1:LEN_A+LEN_B]),
        .shift(en_c), .ctl_bit(tap_c), .msb(top_c)
    );

    // R4: a register outvoted by the majority keeps its taps
    assert_minority_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && (tap_a != maj)) |=> ($stable(tap_a) && $stable(top_a)));

endmodule

// File: rtl/kstream_ctrl.sv
module kstream_ctrl
    import kstream_pkg::*;
#(
    parameter int WARMUP = 64,
    parameter int BYTES  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    output logic                 step_en,
    output logic                 valid,
    output logic [$clog2(BYTES)-1:0] byte_idx,
    output logic                 byte_last
);

    localparam int WCW = (WARMUP > 1) ? $clog2(WARMUP) : 1;
    localparam int BW  = $clog2(BYTES);
    localparam ks_state_t START_ST = (WARMUP == 0) ? ST_RUN : ST_WARM;

    ks_state_t      state_q, state_d;
    logic [WCW-1:0] wcnt_q;
    logic [BW-1:0]  cnt_q;
    logic           valid_q;
    logic           warm_last;
    logic           emit;

    assign warm_last = (wcnt_q == WCW'(WARMUP - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = START_ST;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WARM: if (step && warm_last) state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        step_en = 1'b0;
        emit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_en = 1'b0;
            end
            ST_WARM: begin
                step_en = step && !load;
            end
            ST_RUN: begin
                step_en = step && !load;
                emit    = step && !load;
            end
            default: begin
                step_en = 1'b0;
            end
        endcase
    end

    // counters and byte valid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            wcnt_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit;
            if (state_q == ST_WARM && step) wcnt_q <= wcnt_q + 1'b1;
            if (valid_q) cnt_q <= (cnt_q == BW'(BYTES - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    assign valid     = valid_q;
    assign byte_idx  = cnt_q;
    assign byte_last = (cnt_q == BW'(BYTES - 1));

    // R1: no byte before the first load
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> !valid_q);

    // R5: every valid byte comes from a step taken while running
    assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(step && !load && state_q == ST_RUN));

    // R6: warm-up steps never yield a byte
    assert_warm_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && step && !load) |=> !valid_q);

    // R8: a load restarts the sequence
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!valid_q && cnt_q == '0 && state_q == START_ST));

endmodule

// File: rtl/kstream_gen.sv
module kstream_gen #(
    parameter int NCELL    = 8,
    parameter int KEY_W    = 128,
    parameter int ROT_STEP = 16,
    parameter int WARMUP   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_in,
    input  logic             key_load,
    input  logic             step,
    output logic [NCELL-1:0] ks_byte,
    output logic             ks_valid,
    output logic [KEY_W-1:0] rkey,
    output logic             rkey_ready
);

    localparam int BYTES = KEY_W / NCELL;
    localparam int BW    = $clog2(BYTES);

    logic          step_en;
    logic [BW-1:0] byte_idx;
    logic          byte_last;
    logic [KEY_W-1:0] acc_q;

    kstream_ctrl #(.WARMUP(WARMUP), .BYTES(BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(key_load), .step(step),
        .step_en(step_en), .valid(ks_valid),
        .byte_idx(byte_idx), .byte_last(byte_last)
    );

    for (genvar n = 0; n < NCELL; n++) begin : g_cell
        localparam int ROT = (n * ROT_STEP) % KEY_W;
        logic [KEY_W-1:0] ckey;
        if (ROT == 0) begin : g_norot
            assign ckey = key_in;
        end else begin : g_rot
            assign ckey = {key_in[KEY_W-ROT-1:0], key_in[KEY_W-1:KEY_W-ROT]};
        end
        kstream_cell #(.KEY_W(KEY_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .load(key_load),
            .cell_key(ckey), .step_en(step_en), .out_bit(ks_byte[n])
        );
    end

    // round key assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= '0;
            rkey       <= '0;
            rkey_ready <= 1'b0;
        end else begin
            rkey_ready <= 1'b0;
            if (ks_valid && !key_load) begin
                acc_q[byte_idx*NCELL +: NCELL] <= ks_byte;
                if (byte_last) begin
                    rkey       <= {ks_byte, acc_q[KEY_W-NCELL-1:0]};
                    rkey_ready <= 1'b1;
                end
            end
        end
    end

    // R7: the ready flag is a lone pulse that follows a valid byte
    assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rkey_ready |=> !rkey_ready);

    assert_ready_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rkey_ready |-> $past(ks_valid));

endmodule

// File: tb/kstream_gen_test.sv
`timescale 1ns/1ps
module kstream_gen_test;

    localparam int WARM = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] key_in = '0;
    logic         key_load = 1'b0;
    logic         step = 1'b0;
    logic [7:0]   ks_byte;
    logic         ks_valid;
    logic [127:0] rkey;
    logic         rkey_ready;

    always #2 clk = ~clk;

    kstream_gen #(.NCELL(8), .KEY_W(128), .ROT_STEP(16), .WARMUP(WARM)) uut (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_load(key_load),
        .step(step), .ks_byte(ks_byte), .ks_valid(ks_valid),
        .rkey(rkey), .rkey_ready(rkey_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [37:0] ma [8];
    logic [42:0] mb [8];
    logic [46:0] mc [8];
    int          m_cnt;
    logic [127:0] m_acc;

    function automatic logic [127:0] rotl(input logic [127:0] v, input int r);
        logic [255:0] d;
        d = {v, v} << r;
        return d[255:128];
    endfunction

    function automatic void model_load(input logic [127:0] k);
        for (int n = 0; n < 8; n++) begin
            logic [127:0] r;
            r = rotl(k, 16 * n);
            ma[n] = r[37:0];
            mb[n] = r[80:38];
            mc[n] = r[127:81];
        end
    endfunction

    function automatic void model_step();
        for (int n = 0; n < 8; n++) begin
            logic ta, tb, tc, mj;
            ta = ma[n][19]; tb = mb[n][21]; tc = mc[n][23];
            mj = (ta + tb + tc) >= 2;
            if (ta == mj) ma[n] = {ma[n][36:0], ma[n][37] ^ ma[n][5] ^ ma[n][4] ^ ma[n][0]};
            if (tb == mj) mb[n] = {mb[n][41:0], mb[n][42] ^ mb[n][5] ^ mb[n][3] ^ mb[n][2]};
            if (tc == mj) mc[n] = {mc[n][45:0], mc[n][46] ^ mc[n][4]};
        end
    endfunction

    function automatic logic [7:0] model_byte();
        logic [7:0] b;
        for (int n = 0; n < 8; n++) b[n] = ma[n][37] ^ mb[n][42] ^ mc[n][46];
        return b;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_key(input logic [127:0] k, input bit with_step);
        key_in = k; key_load = 1'b1; step = with_step;
        @(negedge clk);
        key_load = 1'b0; step = 1'b0;
        model_load(k);
        m_cnt = 0;
        chk("R8 no byte in cycle after load", {127'd0, ks_valid}, 128'd0);
        chk("R2 byte of loaded state", {120'd0, ks_byte}, {120'd0, model_byte()});
    endtask

    task automatic step_once(input bit exp_valid, input string tag);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        if (exp_valid) model_step();
        chk(tag, {127'd0, ks_valid}, {127'd0, exp_valid});
        if (exp_valid) begin
            chk("R3 R4 R5 byte value", {120'd0, ks_byte}, {120'd0, model_byte()});
            chk("R7 no early ready", {127'd0, rkey_ready}, 128'd0);
            m_acc[m_cnt*8 +: 8] = model_byte();
            m_cnt++;
            if (m_cnt == 16) begin
                @(negedge clk);
                chk("R7 ready pulse", {127'd0, rkey_ready}, 128'd1);
                chk("R7 assembled key", rkey, m_acc);
                @(negedge clk);
                chk("R7 ready one cycle", {127'd0, rkey_ready}, 128'd0);
                chk("R7 key held", rkey, m_acc);
                m_cnt = 0;
            end
        end
    endtask

    task automatic warm_steps();
        for (int i = 0; i < WARM; i++) begin
            model_step();
            step_once(1'b0, "R6 silent during warm-up");
        end
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 idle no valid", {127'd0, ks_valid}, 128'd0);
            chk("R9 idle byte held", {120'd0, ks_byte}, {120'd0, model_byte()});
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset valid", {127'd0, ks_valid}, 128'd0);
        chk("R1 reset ready", {127'd0, rkey_ready}, 128'd0);
        chk("R1 reset rkey", rkey, 128'd0);
        chk("R1 reset byte", {120'd0, ks_byte}, 128'd0);
        for (int i = 0; i < 3; i++) step_once(1'b0, "R1 step before load ignored");

        // all-zero key stays zero
        load_key(128'd0, 1'b0);
        warm_steps();
        for (int i = 0; i < 16; i++) step_once(1'b1, "R5 valid with zero key");

        // random keys, random gaps
        for (int t = 0; t < 3; t++) begin
            load_key({$urandom, $urandom, $urandom, $urandom}, 1'b0);
            warm_steps();
            for (int i = 0; i < 32; i++) begin
                idle_gap($urandom_range(0, 2));
                step_once(1'b1, "R5 valid after step");
            end
        end

        // load and step in the same cycle: step ignored, full warm-up follows
        load_key({$urandom, $urandom, $urandom, $urandom}, 1'b1);
        warm_steps();
        step_once(1'b1, "R6 R8 first byte after full warm-up");

        // reload in the middle of a key
        for (int i = 0; i < 4; i++) step_once(1'b1, "R5 valid before reload");
        load_key(128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0);
        warm_steps();
        for (int i = 0; i < 16; i++) step_once(1'b1, "R8 count restarted");
        idle_gap(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule